// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps a small number of recent virtual-to-physical page mappings close to the address path of a memory management unit. A requester presents a virtual page number. In the same cycle the block reports whether it holds a mapping for that page, and on a hit it returns the physical page number. The page offset bypasses the block, and the requester joins it to the returned frame number.

The default configuration holds sixteen mappings in four sets of four ways. The low bits of the virtual page number select a set, and the remaining upper bits form the tag. All ways of the selected set are compared in parallel. When a lookup misses, the miss output tells an external page-table walker to fetch the mapping. The walker then writes the mapping back through the fill port.

A fill picks its target way in a fixed order:
1. A way that already holds the same tag.
2. Otherwise, the lowest-numbered empty way.
3. Otherwise, the way named by a per-set rotating pointer.

A global invalidate input empties the whole structure in a single cycle.

Top module: `tlb_sa_top`

## Requirements
- R1: After reset every entry is empty, so every requested lookup reports miss=1 and hit=0.
- R2: With the default sizes, virtual page number bits [1:0] select the set and bits [7:2] form the tag. After a fill of page 0x0F with frame 0x0D, a lookup of page 0x0F hits in set 3 (tag 0x03) and returns 0x0D.
- R3: A lookup is combinational. hit and frame reflect the presented page number in the same cycle, and the frame output is 0 whenever hit is 0.
- R4: miss equals request AND NOT hit. With the request low, both hit and miss are 0.
- R5: An empty entry never hits, even if its stored tag equals the probe tag, for example after an invalidate.
- R6: A fill whose tag is not present in the set writes the lowest-numbered empty way of that set.
- R7: A fill into a set whose ways are all occupied and that lacks the tag replaces the way named by that set's 2-bit pointer. The pointer advances by one (modulo 4) on every fill into the set.
- R8: A fill whose tag is already present in the set overwrites the frame in that same way and creates no second copy.
- R9: Invalidate clears every entry and every pointer to 0 at the next clock edge. It takes priority over a fill in the same cycle, which is then dropped.
- R10: A fill takes effect at the next rising clock edge. A lookup in the cycle of the fill still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_hit_o | output | 1 | Mapping found |
| lk_miss_o | output | 1 | Request made, mapping absent |
| lk_ppn_o | output | PPN_W | Physical page number on a hit, else 0 |
| fl_valid_i | input | 1 | Write a mapping this cycle |
| fl_vpn_i | input | VPN_W | Virtual page number of the mapping |
| fl_ppn_i | input | PPN_W | Physical page number of the mapping |
| inv_all_i | input | 1 | Empty every entry and reset the pointers |

## Verification
The hardest condition to reach from the ports is a replacement whose victim depends on the rotating pointer. The pointer has been moved by earlier fills, some of which hit an existing tag or landed in an empty way.

The pointer is never visible directly, so the bench drives long chains of fills that alias into the same sets. After each group of fills it sweeps all 256 page numbers. Each sweep compares hit, miss and frame against an arithmetic model of the victim order.

Stale tags left behind by an invalidate are checked the same way. The bench also checks that the pointer restarts from way 0, by observing which entry is evicted first after refilling a set.

// File: rtl/tlb_sa_pkg.sv
package tlb_sa_pkg;
  // Isolate the lowest set bit of a vector (up to 32 ways).
  function automatic logic [31:0] lowest_one(logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction
endpackage

// File: rtl/tlb_sa_set_cmp.sv
module tlb_sa_set_cmp #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6
) (
  input  logic [WAYS-1:0]       valid_i,
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]      probe_i,
  output logic [WAYS-1:0]       match_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match_o[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == probe_i);
  end
endmodule

// File: rtl/tlb_sa_victim.sv
module tlb_sa_victim
  import tlb_sa_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  match_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] ptr_i,
  output logic [WAYS-1:0]  way_oh_o
);
  logic [WAYS-1:0] hit_oh, free_oh, rr_oh;

  assign hit_oh  = WAYS'(lowest_one(32'(match_i)));
  assign free_oh = WAYS'(lowest_one(32'(~valid_i)));
  assign rr_oh   = WAYS'(32'd1 << ptr_i);

  always_comb begin
    if (|match_i)       way_oh_o = hit_oh;
    else if (~&valid_i) way_oh_o = free_oh;
    else                way_oh_o = rr_oh;
  end
endmodule

// File: rtl/tlb_sa_store.sv
module tlb_sa_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  parameter int IDX_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        inv_i,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_set_i,
  input  logic [WAYS-1:0]             wr_way_oh_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic [PPN_W-1:0]            wr_ppn_i,
  output logic [SETS*WAYS-1:0]        valid_o,
  output logic [SETS*WAYS*TAG_W-1:0]  tag_o,
  output logic [SETS*WAYS*PPN_W-1:0]  ppn_o,
  output logic [SETS*WAY_W-1:0]       ptr_o
);
  localparam int ENTRIES = SETS * WAYS;
  localparam logic [WAY_W-1:0] PTR_ONE = WAY_W'(1);

  logic [ENTRIES-1:0]       valid_q, valid_d;
  logic [ENTRIES*TAG_W-1:0] tag_q, tag_d;
  logic [ENTRIES*PPN_W-1:0] ppn_q, ppn_d;
  logic [SETS*WAY_W-1:0]    ptr_q, ptr_d;
  logic                     data_en;

  assign data_en = wr_en_i && !inv_i;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    ppn_d   = ppn_q;
    ptr_d   = ptr_q;
    if (inv_i) begin
      valid_d = '0;
      ptr_d   = '0;
    end else if (wr_en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wr_way_oh_i[w]) begin
          valid_d[int'(wr_set_i)*WAYS + w]                  = 1'b1;
          tag_d[(int'(wr_set_i)*WAYS + w)*TAG_W +: TAG_W]   = wr_tag_i;
          ppn_d[(int'(wr_set_i)*WAYS + w)*PPN_W +: PPN_W]   = wr_ppn_i;
        end
      end
      ptr_d[int'(wr_set_i)*WAY_W +: WAY_W] =
        ptr_q[int'(wr_set_i)*WAY_W +: WAY_W] + PTR_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (inv_i || wr_en_i) begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (data_en) begin
      tag_q <= tag_d;
      ppn_q <= ppn_d;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign ppn_o   = ppn_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/tlb_sa_top.sv
module tlb_sa_top #(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_req_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic             lk_miss_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  input  logic             fl_valid_i,
  input  logic [VPN_W-1:0] fl_vpn_i,
  input  logic [PPN_W-1:0] fl_ppn_i,
  input  logic             inv_all_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [SETS*WAYS-1:0]       valid_all;
  logic [SETS*WAYS*TAG_W-1:0] tag_all;
  logic [SETS*WAYS*PPN_W-1:0] ppn_all;
  logic [SETS*WAY_W-1:0]      ptr_all;

  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [WAYS-1:0]  lk_valid, fl_valid_row, lk_match, fl_match, fl_way_oh;
  logic [WAYS*TAG_W-1:0] lk_tags, fl_tags;
  logic [WAYS*PPN_W-1:0] lk_ppns;
  logic [WAY_W-1:0] fl_ptr;

  assign lk_set = lk_vpn_i[IDX_W-1:0];
  assign lk_tag = lk_vpn_i[VPN_W-1:IDX_W];
  assign fl_set = fl_vpn_i[IDX_W-1:0];
  assign fl_tag = fl_vpn_i[VPN_W-1:IDX_W];

  assign lk_valid     = valid_all[int'(lk_set)*WAYS +: WAYS];
  assign lk_tags      = tag_all[int'(lk_set)*WAYS*TAG_W +: WAYS*TAG_W];
  assign lk_ppns      = ppn_all[int'(lk_set)*WAYS*PPN_W +: WAYS*PPN_W];
  assign fl_valid_row = valid_all[int'(fl_set)*WAYS +: WAYS];
  assign fl_tags      = tag_all[int'(fl_set)*WAYS*TAG_W +: WAYS*TAG_W];
  assign fl_ptr       = ptr_all[int'(fl_set)*WAY_W +: WAY_W];

  tlb_sa_set_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) lk_cmp_i (
    .valid_i(lk_valid), .tags_i(lk_tags), .probe_i(lk_tag), .match_o(lk_match)
  );

  tlb_sa_set_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) fl_cmp_i (
    .valid_i(fl_valid_row), .tags_i(fl_tags), .probe_i(fl_tag), .match_o(fl_match)
  );

  tlb_sa_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) victim_i (
    .match_i(fl_match), .valid_i(fl_valid_row), .ptr_i(fl_ptr), .way_oh_o(fl_way_oh)
  );

  tlb_sa_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) store_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .inv_i(inv_all_i), .wr_en_i(fl_valid_i),
    .wr_set_i(fl_set), .wr_way_oh_i(fl_way_oh), .wr_tag_i(fl_tag), .wr_ppn_i(fl_ppn_i),
    .valid_o(valid_all), .tag_o(tag_all), .ppn_o(ppn_all), .ptr_o(ptr_all)
  );

  always_comb begin
    lk_ppn_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_req_i && lk_match[w]) lk_ppn_o |= lk_ppns[w*PPN_W +: PPN_W];
    end
  end

  assign lk_hit_o  = lk_req_i && (|lk_match);
  assign lk_miss_o = lk_req_i && !(|lk_match);
endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk #(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_req_i,
  input logic [VPN_W-1:0] lk_vpn_i,
  input logic             lk_hit_o,
  input logic             lk_miss_o,
  input logic [PPN_W-1:0] lk_ppn_o,
  input logic             fl_valid_i,
  input logic [VPN_W-1:0] fl_vpn_i,
  input logic [PPN_W-1:0] fl_ppn_i,
  input logic             inv_all_i
);
  p_hit_miss_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o));

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |-> (!lk_hit_o && !lk_miss_o));

  p_ppn_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_ppn_o == '0));

  p_inv_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(inv_all_i) && lk_req_i) |-> !lk_hit_o);

  p_fill_visible_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fl_valid_i) && !$past(inv_all_i) && lk_req_i && (lk_vpn_i == $past(fl_vpn_i)))
      |-> (lk_hit_o && (lk_ppn_o == $past(fl_ppn_i))));
endmodule

bind tlb_sa_top tlb_sa_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .lk_vpn_i(lk_vpn_i),
  .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_ppn_o(lk_ppn_o),
  .fl_valid_i(fl_valid_i), .fl_vpn_i(fl_vpn_i), .fl_ppn_i(fl_ppn_i),
  .inv_all_i(inv_all_i)
);

// File: tb/tlb_sa_top_tb_top.sv
module tlb_sa_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lk_req = 1'b0;
  logic [7:0] lk_vpn = '0;
  logic       lk_hit, lk_miss;
  logic [5:0] lk_ppn;
  logic       fl_valid = 1'b0;
  logic [7:0] fl_vpn = '0;
  logic [5:0] fl_ppn = '0;
  logic       inv_all = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_tag [4][4];
  int m_ppn [4][4];
  bit m_val [4][4];
  int m_ptr [4];

  always #10 clk = ~clk;

  tlb_sa_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lk_req_i(lk_req), .lk_vpn_i(lk_vpn),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_ppn_o(lk_ppn),
    .fl_valid_i(fl_valid), .fl_vpn_i(fl_vpn), .fl_ppn_i(fl_ppn), .inv_all_i(inv_all)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int s = 0; s < 4; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 4; w++) m_val[s][w] = 0;
    end
  endfunction

  function automatic void model_fill(int vpn, int ppn);
    int s = vpn % 4;
    int t = vpn / 4;
    int way = -1;
    for (int w = 0; w < 4; w++) if (way < 0 && m_val[s][w] && m_tag[s][w] == t) way = w;
    for (int w = 0; w < 4; w++) if (way < 0 && !m_val[s][w]) way = w;
    if (way < 0) way = m_ptr[s];
    m_val[s][way] = 1;
    m_tag[s][way] = t;
    m_ppn[s][way] = ppn;
    m_ptr[s] = (m_ptr[s] + 1) % 4;
  endfunction

  // Returns -1 on miss, else frame number.
  function automatic int model_look(int vpn);
    int s = vpn % 4;
    int t = vpn / 4;
    for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == t) return m_ppn[s][w];
    return -1;
  endfunction

  task automatic fill(int vpn, int ppn);
    @(negedge clk);
    fl_valid = 1'b1;
    fl_vpn   = 8'(vpn);
    fl_ppn   = 6'(ppn);
    @(posedge clk);
    model_fill(vpn, ppn);
    @(negedge clk);
    fl_valid = 1'b0;
  endtask

  task automatic look_one(int vpn, string req);
    int e;
    lk_req = 1'b1;
    lk_vpn = 8'(vpn);
    #1;
    e = model_look(vpn);
    if (e < 0)
      check(!lk_hit && lk_miss && lk_ppn == 0, req, {lk_hit, lk_miss, lk_ppn}, 8'h40);
    else
      check(lk_hit && !lk_miss && lk_ppn == 6'(e), req, {lk_hit, lk_miss, lk_ppn}, 8'h80 | e);
  endtask

  task automatic sweep(string req);
    @(negedge clk);
    for (int v = 0; v < 256; v++) look_one(v, req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    sweep("R1");

    // R4: no request -> quiet outputs
    @(negedge clk);
    lk_req = 1'b0;
    for (int v = 0; v < 256; v += 17) begin
      lk_vpn = 8'(v);
      #1;
      check(!lk_hit && !lk_miss, "R4", {lk_hit, lk_miss}, 0);
    end

    // R2: index/tag split, page 0x0F -> frame 0x0D in set 3
    fill(8'h0F, 6'h0D);
    look_one(8'h0F, "R2");
    check(lk_ppn == 6'h0D, "R2", lk_ppn, 6'h0D);
    look_one(8'h0B, "R2");
    look_one(8'h0E, "R2");
    sweep("R3");

    // R10: lookup in the fill cycle sees the old contents
    @(negedge clk);
    fl_valid = 1'b1; fl_vpn = 8'h21; fl_ppn = 6'h11;
    lk_req = 1'b1; lk_vpn = 8'h21;
    #1;
    check(lk_miss && !lk_hit, "R10", {lk_hit, lk_miss}, 1);
    @(posedge clk);
    model_fill(8'h21, 6'h11);
    @(negedge clk);
    fl_valid = 1'b0;
    #1;
    check(lk_hit && lk_ppn == 6'h11, "R10", lk_ppn, 6'h11);

    // R6: empty ways filled lowest first (set 2)
    fill(8'h02, 6'h01);
    fill(8'h06, 6'h02);
    fill(8'h0A, 6'h03);
    sweep("R6");

    // R7: replacement by rotating pointer in set 2
    fill(8'h12, 6'h04);
    fill(8'h16, 6'h05);
    fill(8'h1A, 6'h06);
    sweep("R7");

    // R8: refill of an existing page overwrites in place
    fill(8'h0F, 6'h2A);
    look_one(8'h0F, "R8");
    fill(8'h16, 6'h3C);
    fill(8'h1E, 6'h07);
    fill(8'h22, 6'h08);
    sweep("R8");

    // R7: long aliasing chain across all sets
    for (int i = 0; i < 60; i++) begin
      fill((i * 37 + 5) & 255, (i * 11 + 3) & 63);
      if (i % 10 == 9) sweep("R7");
    end

    // R5: invalidate leaves stale tags that must not hit
    @(negedge clk);
    inv_all = 1'b1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    inv_all = 1'b0;
    sweep("R5");

    // R9: invalidate beats a fill in the same cycle
    fill(8'h44, 6'h15);
    @(negedge clk);
    inv_all = 1'b1; fl_valid = 1'b1; fl_vpn = 8'h48; fl_ppn = 6'h16;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    inv_all = 1'b0; fl_valid = 1'b0;
    look_one(8'h48, "R9");
    look_one(8'h44, "R9");

    // R9: pointer restarted at way 0 -> first filled entry evicted first
    fill(8'h00, 6'h21);
    fill(8'h04, 6'h22);
    fill(8'h08, 6'h23);
    fill(8'h0C, 6'h24);
    fill(8'h10, 6'h25);
    look_one(8'h00, "R9");
    look_one(8'h04, "R9");
    sweep("R9");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule